// File: doc/BRIEF.md
# Masked Interrupt Controller With Ring Log

This block gathers four single-cycle event strobes from a monitoring engine (memory-access failure, self-test failure, message error and record-count-reached-zero), filters them through a host-written enable mask, and accumulates the survivors in a pending register. The events fall into two classes. Each class drives its own interrupt output as a fixed-length pulse: message events on one line, fault events on the other.

The host reaches the block through a small register port with four word registers: mask, pending, log pointer and control. The pending register clears itself one access later. A read of it leaves its content in place. The next access to any other register empties it. When logging is enabled, every cycle that latches new events also writes one word into a 32-entry ring in external memory. The ring sits at a 32-word-aligned base set by the host, and the block advances the low five bits of the pointer.

Top module: `irqlog_top`

## Requirements
- R1: After reset, all four registers read 0x0000, and msgIrq, faultIrq and logWrEn are low.
- R2: Register select on hostAddr: 0 = mask, 1 = pending, 2 = log pointer, 3 = control (bit 0 = log enable). Event lines map to register bits as follows: evtIn[0] count-zero to bit 0, evtIn[1] message error to bit 11, evtIn[2] self-test fail to bit 12, evtIn[3] memory fail to bit 15. Only those four bits are stored in the mask and pending registers, and all other bits read 0.
- R3: An event whose mask bit is 0 is dropped. It does not set pending, pulse an output or write a log entry, and setting the mask bit later does not produce it.
- R4: An unmasked message-error or count-zero event raises msgIrq in the cycle after the event for exactly 3 cycles.
- R5: An unmasked memory-fail or self-test-fail event raises faultIrq in the cycle after the event for exactly 3 cycles.
- R6: A host write to the pending register with any of bits 15:12 set gives a 3-cycle faultIrq pulse and leaves the pending content unchanged. With those bits clear, the write has no effect.
- R7: A read of the pending register does not clear it, and neither do repeated reads of it. The first later access (read or write) to any other register clears it at the end of that access.
- R8: An event that arrives in the same cycle as that clearing access stays latched in pending.
- R9: With log enable at 1, each cycle that latches new events writes one word into the ring. The word holds that cycle's newly latched bits, and the address is the current pointer. The low five pointer bits then advance, wrapping from 31 to 0, and the upper 11 bits stay as the host wrote them.
- R10: With log enable at 0, interrupts still pulse, but no log write occurs and the pointer does not move.
- R11: Two events of different classes in the same cycle both set their pending bits and pulse both outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtIn | input | 4 | Event strobes: [3] memory fail, [2] self-test fail, [1] message error, [0] count zero |
| hostSel | input | 1 | Host register access this cycle |
| hostWe | input | 1 | 1 = write, 0 = read |
| hostAddr | input | 2 | Register select |
| hostWdata | input | 16 | Write data |
| hostRdata | output | 16 | Read data for hostAddr (combinational) |
| msgIrq | output | 1 | Message-class interrupt pulse |
| faultIrq | output | 1 | Fault-class interrupt pulse |
| logWrEn | output | 1 | Log write strobe to memory |
| logAddr | output | 16 | Log write address |
| logData | output | 16 | Log write word |

## Verification
The bench targets the timing of the self-clear. It reads pending twice in a row to check that a design clearing on the read itself, or on any repeated access, loses the bits. In the same cycle as a clearing access it injects a new event, which a design that clears after the merge would drop. It masks an event and unmasks it later to catch a design that holds masked events back instead of discarding them. It drives enough logged events to cross index 31, so a carry into the base bits appears as a wrong write address. It fires a two-class event and a forced fault write so that a missing or swapped pulse path shows on the outputs.

// File: rtl/irqlog_pkg.sv
package irqlog_pkg;
  localparam int DW = 16;

  typedef enum logic [1:0] {
    REG_MASK   = 2'd0,
    REG_PEND   = 2'd1,
    REG_LOGPTR = 2'd2,
    REG_CTRL   = 2'd3
  } regSel_e;

  localparam logic [DW-1:0] BIT_CNTZ    = 16'h0001;
  localparam logic [DW-1:0] BIT_MSGERR  = 16'h0800;
  localparam logic [DW-1:0] BIT_TESTF   = 16'h1000;
  localparam logic [DW-1:0] BIT_MEMF    = 16'h8000;
  localparam logic [DW-1:0] IRQ_BITS    = BIT_CNTZ | BIT_MSGERR | BIT_TESTF | BIT_MEMF;
  localparam logic [DW-1:0] MSG_CLASS   = BIT_CNTZ | BIT_MSGERR;
  localparam logic [DW-1:0] FAULT_CLASS = BIT_TESTF | BIT_MEMF;

  typedef struct packed {
    logic wrMask;
    logic wrLogPtr;
    logic wrCtrl;
    logic forceFault;
    logic clrPend;
  } hostStrb_t;

  function automatic logic [DW-1:0] mapEvents(input logic [3:0] ev);
    mapEvents = (ev[0] ? BIT_CNTZ   : '0) |
                (ev[1] ? BIT_MSGERR : '0) |
                (ev[2] ? BIT_TESTF  : '0) |
                (ev[3] ? BIT_MEMF   : '0);
  endfunction
endpackage

// File: rtl/irqlog_ctrl.sv
module irqlog_ctrl
  import irqlog_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       hostSel,
  input  logic       hostWe,
  input  logic [1:0] hostAddr,
  input  logic [3:0] pendHiBits,
  output hostStrb_t  strb
);
  regSel_e sel;
  logic    isWr;
  logic    isRd;
  logic    otherAccess;
  logic    armed;

  assign sel         = regSel_e'(hostAddr);
  assign isWr        = hostSel && hostWe;
  assign isRd        = hostSel && !hostWe;
  assign otherAccess = hostSel && (sel != REG_PEND);

  always_comb begin
    strb            = '0;
    strb.wrMask     = isWr && (sel == REG_MASK);
    strb.wrLogPtr   = isWr && (sel == REG_LOGPTR);
    strb.wrCtrl     = isWr && (sel == REG_CTRL);
    strb.forceFault = isWr && (sel == REG_PEND) && (|pendHiBits);
    strb.clrPend    = otherAccess && armed;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b0;
    end else if (isRd && (sel == REG_PEND)) begin
      armed <= 1'b1;
    end else if (otherAccess) begin
      armed <= 1'b0;
    end
  end

  // R7
  arm_after_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(armed) |-> $past(isRd && hostAddr == 2'd1));
endmodule

// File: rtl/irqlog_datapath.sv
module irqlog_datapath
  import irqlog_pkg::*;
#(
  parameter int PULSE_LEN = 3,
  parameter int LOG_IDX_W = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic [3:0]    evtIn,
  input  hostStrb_t     strb,
  input  logic [1:0]    hostAddr,
  input  logic [DW-1:0] hostWdata,
  output logic [DW-1:0] hostRdata,
  output logic          msgIrq,
  output logic          faultIrq,
  output logic          logWrEn,
  output logic [DW-1:0] logAddr,
  output logic [DW-1:0] logData
);
  localparam int CW     = $clog2(PULSE_LEN + 1);
  localparam int BASE_W = DW - LOG_IDX_W;

  logic [DW-1:0] maskReg;
  logic [DW-1:0] pendReg;
  logic [DW-1:0] logPtr;
  logic          logEn;
  logic [DW-1:0] newBits;
  logic          doLog;
  logic [1:0]    trig;
  logic [1:0]    irqOut;

  assign newBits = mapEvents(evtIn) & maskReg;
  assign doLog   = logEn && (|newBits);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskReg <= '0;
      pendReg <= '0;
      logEn   <= 1'b0;
    end else begin
      pendReg <= strb.clrPend ? newBits : (pendReg | newBits);
      if (strb.wrMask) maskReg <= hostWdata & IRQ_BITS;
      if (strb.wrCtrl) logEn   <= hostWdata[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      logPtr  <= '0;
      logWrEn <= 1'b0;
      logAddr <= '0;
      logData <= '0;
    end else begin
      logWrEn <= doLog;
      if (doLog) begin
        logAddr <= logPtr;
        logData <= newBits;
      end
      if (strb.wrLogPtr) begin
        logPtr <= hostWdata;
      end else if (doLog) begin
        logPtr <= {logPtr[DW-1:LOG_IDX_W], logPtr[LOG_IDX_W-1:0] + 1'b1};
      end
    end
  end

  assign trig[0] = |(newBits & MSG_CLASS);
  assign trig[1] = (|(newBits & FAULT_CLASS)) || strb.forceFault;

  for (genvar ch = 0; ch < 2; ch++) begin : g_pulse
    logic [CW-1:0] cnt;
    always_ff @(posedge clk) begin
      if (!rstN)            cnt <= '0;
      else if (trig[ch])    cnt <= CW'(PULSE_LEN);
      else if (cnt != '0)   cnt <= cnt - 1'b1;
    end
    assign irqOut[ch] = (cnt != '0);
  end

  assign msgIrq   = irqOut[0];
  assign faultIrq = irqOut[1];

  always_comb begin
    case (regSel_e'(hostAddr))
      REG_MASK:   hostRdata = maskReg;
      REG_PEND:   hostRdata = pendReg;
      REG_LOGPTR: hostRdata = logPtr;
      default:    hostRdata = {{(DW-1){1'b0}}, logEn};
    endcase
  end

  // R3
  masked_drop_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendReg & ~$past(pendReg) & ~$past(maskReg)) == '0));

  // R2
  reserved_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    ((pendReg & ~IRQ_BITS) == '0) && ((maskReg & ~IRQ_BITS) == '0));

  // R10
  log_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    logWrEn |-> $past(logEn));

  // R9
  idx_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (logWrEn && !$past(strb.wrLogPtr)) |->
      (logPtr[LOG_IDX_W-1:0] == logAddr[LOG_IDX_W-1:0] + 1'b1) &&
      (logPtr[DW-1:LOG_IDX_W] == $past(logPtr[DW-1:LOG_IDX_W])));

  logic unusedBase;
  assign unusedBase = ^BASE_W;
endmodule

// File: rtl/irqlog_top.sv
module irqlog_top
  import irqlog_pkg::*;
#(
  parameter int PULSE_LEN = 3,
  parameter int LOG_IDX_W = 5
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic [3:0]  evtIn,
  input  logic        hostSel,
  input  logic        hostWe,
  input  logic [1:0]  hostAddr,
  input  logic [15:0] hostWdata,
  output logic [15:0] hostRdata,
  output logic        msgIrq,
  output logic        faultIrq,
  output logic        logWrEn,
  output logic [15:0] logAddr,
  output logic [15:0] logData
);
  hostStrb_t strb;

  irqlog_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .hostSel    (hostSel),
    .hostWe     (hostWe),
    .hostAddr   (hostAddr),
    .pendHiBits (hostWdata[15:12]),
    .strb       (strb)
  );

  irqlog_datapath #(
    .PULSE_LEN (PULSE_LEN),
    .LOG_IDX_W (LOG_IDX_W)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .evtIn     (evtIn),
    .strb      (strb),
    .hostAddr  (hostAddr),
    .hostWdata (hostWdata),
    .hostRdata (hostRdata),
    .msgIrq    (msgIrq),
    .faultIrq  (faultIrq),
    .logWrEn   (logWrEn),
    .logAddr   (logAddr),
    .logData   (logData)
  );
endmodule

// File: tb/tb_irqlog_top.sv
module tb_irqlog_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [3:0]  evtIn = '0;
  logic        hostSel = 1'b0;
  logic        hostWe = 1'b0;
  logic [1:0]  hostAddr = '0;
  logic [15:0] hostWdata = '0;
  logic [15:0] hostRdata;
  logic        msgIrq, faultIrq, logWrEn;
  logic [15:0] logAddr, logData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  logic [15:0] mPend = '0, mMask = '0, mPtr = '0;
  bit          mArmed = 0, mLogOn = 0;
  logic [31:0] expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  irqlog_top dut (
    .clk(clk), .rstN(rstN), .evtIn(evtIn), .hostSel(hostSel), .hostWe(hostWe),
    .hostAddr(hostAddr), .hostWdata(hostWdata), .hostRdata(hostRdata),
    .msgIrq(msgIrq), .faultIrq(faultIrq), .logWrEn(logWrEn),
    .logAddr(logAddr), .logData(logData)
  );

  function automatic logic [15:0] evBits(input logic [3:0] e);
    evBits = {e[3], 2'b00, e[2], e[1], 10'd0, e[0]};
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One cycle of stimulus; the model is updated as the design should update at the edge.
  task automatic cycle(input bit sel, input bit we, input logic [1:0] a,
                       input logic [15:0] wd, input logic [3:0] ev, output logic [15:0] rd);
    logic [15:0] nb;
    @(negedge clk);
    hostSel = sel; hostWe = we; hostAddr = a; hostWdata = wd; evtIn = ev;
    #1 rd = hostRdata;
    nb = evBits(ev) & mMask;
    if (sel && a != 2'd1 && mArmed) mPend = nb; else mPend = mPend | nb;
    if (sel && !we && a == 2'd1) mArmed = 1;
    else if (sel && a != 2'd1) mArmed = 0;
    if (mLogOn && nb != 0) begin
      expQ.push_back({mPtr, nb});
      mPtr = {mPtr[15:5], mPtr[4:0] + 5'd1};
    end
    if (sel && we && a == 2'd0) mMask = wd & 16'h9801;
    if (sel && we && a == 2'd3) mLogOn = wd[0];
    if (sel && we && a == 2'd2) mPtr = wd;
    @(posedge clk);
    #1 hostSel = 0; hostWe = 0; evtIn = '0;
  endtask

  task automatic rdReg(input logic [1:0] a, input logic [15:0] exp, input string req);
    logic [15:0] rd;
    cycle(1, 0, a, 16'h0, 4'h0, rd);
    check(req, rd, exp);
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [15:0] wd);
    logic [15:0] rd;
    cycle(1, 1, a, wd, 4'h0, rd);
  endtask

  task automatic fire(input logic [3:0] ev);
    logic [15:0] rd;
    cycle(0, 0, 2'd0, 16'h0, ev, rd);
  endtask

  task automatic checkPulse(input bit expMsg, input bit expFault, input string req);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      check(req, {15'd0, msgIrq}, {15'd0, expMsg && i < 3});
      check(req, {15'd0, faultIrq}, {15'd0, expFault && i < 3});
    end
  endtask

  // Scoreboard monitor for log writes (R9, R10)
  always @(negedge clk) begin
    if (rstN && logWrEn) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R10 actual=unexpected log write %h:%h expected=none", logAddr, logData);
      end else begin
        logic [31:0] e;
        e = expQ.pop_front();
        if ({logAddr, logData} !== e) begin
          errors++;
          $display("FAIL R9 actual=%h expected=%h", {logAddr, logData}, e);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R1
    @(negedge clk);
    check("R1", {13'd0, msgIrq, faultIrq, logWrEn}, 16'h0);
    rdReg(2'd0, 16'h0, "R1");
    rdReg(2'd1, 16'h0, "R1");
    rdReg(2'd2, 16'h0, "R1");
    rdReg(2'd3, 16'h0, "R1");
    // R2
    wrReg(2'd0, 16'hFFFF);
    rdReg(2'd0, 16'h9801, "R2");
    // R3
    wrReg(2'd0, 16'h0800);
    fire(4'b0001);
    checkPulse(0, 0, "R3");
    rdReg(2'd1, 16'h0000, "R3");
    wrReg(2'd0, 16'h9801);
    rdReg(2'd1, 16'h0000, "R3");
    // log setup
    wrReg(2'd3, 16'h0001);
    wrReg(2'd2, 16'h0140);
    // R4, R5
    fire(4'b0010);
    checkPulse(1, 0, "R4");
    fire(4'b0100);
    checkPulse(0, 1, "R5");
    // R7
    rdReg(2'd1, 16'h1800, "R7");
    rdReg(2'd1, 16'h1800, "R7");
    rdReg(2'd3, 16'h0001, "R7");
    rdReg(2'd1, 16'h0000, "R7");
    // R8: event during the clearing access
    cycle(1, 0, 2'd3, 16'h0, 4'b1000, rd);
    checkPulse(0, 1, "R8");
    rdReg(2'd1, 16'h8000, "R8");
    // R11
    fire(4'b1001);
    checkPulse(1, 1, "R11");
    rdReg(2'd1, 16'h8001, "R11");
    // R6
    wrReg(2'd1, 16'hF000);
    checkPulse(0, 1, "R6");
    wrReg(2'd1, 16'h0FFF);
    checkPulse(0, 0, "R6");
    rdReg(2'd1, 16'h8001, "R6");
    // R9: index and wrap
    rdReg(2'd2, 16'h0144, "R9");
    for (int i = 0; i < 30; i++) fire(4'b0010);
    repeat (2) @(negedge clk);
    rdReg(2'd2, 16'h0142, "R9");
    check("R9", mPtr, 16'h0142);
    // R10
    wrReg(2'd3, 16'h0000);
    fire(4'b0010);
    checkPulse(1, 0, "R10");
    rdReg(2'd2, 16'h0142, "R10");
    repeat (3) @(negedge clk);
    check("R9", 16'(expQ.size()), 16'h0);
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule